// File: doc/BRIEF.md
# Set/Clear General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port reached through a classic (non-pipelined) Wishbone slave with byte addressing. Software never writes the output latch as a whole word. It writes a mask to a set register or a clear register, and only the bits written as 1 change. A single pin can therefore be toggled without a read-modify-write sequence, so two pieces of software driving different pins cannot overwrite each other.

A direction register chooses, pin by pin, whether the latched value drives the pad. The tristate control is built in: every pin has an output value, an output enable and an input. A read-only pin-state register returns the level of each pad after a two-flop synchronizer.

Bus handling is a two-state machine. `BUS_IDLE` waits for a request (CYC and STB both high). On that edge, `BUS_IDLE -> BUS_ACK` performs the write or captures the read data. `BUS_ACK` asserts ACK for one cycle and always returns `BUS_ACK -> BUS_IDLE`. Without a request, the machine stays in `BUS_IDLE -> BUS_IDLE`.

Top module: `gpio_sc_port`

## Requirements
- R1: After reset, the output latch and the direction register are all zeros. Every `pad_oe` bit is 0, every `pad_out` bit is 0 and `bus_ack` is 0.
- R2: A write to byte offset 0x0 (address bits [3:2] = 0) clears each latch bit whose write-data bit is 1. All other latch bits keep their value.
- R3: A write to byte offset 0x4 (address bits [3:2] = 1) sets each latch bit whose write-data bit is 1. All other latch bits keep their value.
- R4: Byte offset 0x8 (address bits [3:2] = 2) is the direction register, and it can be read and written. `pad_oe` equals the direction register, where 1 means the pin drives. `pad_out` equals the output latch.
- R5: Byte offset 0xC (address bits [3:2] = 3) reads the pad levels through a two-flop synchronizer. A read whose access edge is the first clock edge after a pad change still returns the old level. A read whose access starts two cycles after the change returns the new level. Writes to this offset change nothing.
- R6: ACK is high for exactly one cycle, in the cycle after the clock edge that accepts a request. It is never high without a request in the cycle before.
- R7: Reads of offsets 0x0 and 0x4 return 0.
- R8: `bus_sel` bit b enables data bits 8b+7 down to 8b. On a write, unselected byte lanes leave the latch and the direction register unchanged.
- R9: While CYC or STB is low, ACK stays low and neither the latch nor the direction register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_cyc | input | 1 | Wishbone cycle |
| bus_stb | input | 1 | Wishbone strobe |
| bus_we | input | 1 | Write enable |
| bus_adr | input | ADR_W (8) | Byte address; bits [3:2] select the register |
| bus_sel | input | DATA_W/8 (4) | Byte lane selects |
| bus_wdat | input | DATA_W (32) | Write data |
| bus_rdat | output | DATA_W (32) | Read data, valid while ACK is high |
| bus_ack | output | 1 | Acknowledge |
| pad_out | output | DATA_W (32) | Output value per pin |
| pad_oe | output | DATA_W (32) | Output enable per pin |
| pad_in | input | DATA_W (32) | Pad level per pin |

## Verification
Errors in the latch or the direction register appear on `pad_out` and `pad_oe` in the cycle that ACK rises for the write that caused them. A sampled check after each access therefore localises a wrong mask, a wrong byte lane or a register that updated when it should not have to a single transaction. If the state machine sticks in `BUS_ACK` or re-enters it, ACK lasts two cycles or appears without a request. This shows one cycle after the first acknowledge. A synchronizer with the wrong depth shows up as a pin-state read that sees a pad change one access too early or too late.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } bus_state_e;

    typedef enum logic [1:0] {
        REG_CLEAR = 2'd0,
        REG_SET   = 2'd1,
        REG_DIR   = 2'd2,
        REG_PINS  = 2'd3
    } reg_idx_e;

endpackage

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                chain[s] <= '0;
            end else if (s == 0) begin
                chain[s] <= async_i;
            end else begin
                chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/gpio_sc_bus_fsm.sv
module gpio_sc_bus_fsm
    import gpio_sc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cyc_i,
    input  logic stb_i,
    output logic start_o,
    output logic ack_o
);

    bus_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        start_o = 1'b0;
        ack_o   = 1'b0;
        unique case (state_q)
            BUS_IDLE: begin
                if (cyc_i && stb_i) begin
                    start_o = 1'b1;
                    state_d = BUS_ACK;
                end
            end
            BUS_ACK: begin
                ack_o   = 1'b1;
                state_d = BUS_IDLE;
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |=> !ack_o); // R6

    AST_ACK_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> $past(cyc_i && stb_i)); // R6

    AST_IDLE_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cyc_i && stb_i) && !ack_o |=> !ack_o); // R9

endmodule

// File: rtl/gpio_sc_regs.sv
module gpio_sc_regs
    import gpio_sc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              we_i,
    input  logic [1:0]        idx_i,
    input  logic [DATA_W-1:0] wdat_i,
    input  logic [DATA_W-1:0] lane_mask_i,
    input  logic [DATA_W-1:0] pins_i,
    output logic [DATA_W-1:0] latch_o,
    output logic [DATA_W-1:0] dir_o,
    output logic [DATA_W-1:0] rdat_o
);

    logic [DATA_W-1:0] latch_q, dir_q, rdat_q;
    logic [DATA_W-1:0] bit_mask;
    logic              wr_clr, wr_set, wr_dir, rd_en;
    reg_idx_e          idx;

    assign idx      = reg_idx_e'(idx_i);
    assign bit_mask = wdat_i & lane_mask_i;

    always_comb begin
        wr_clr = 1'b0;
        wr_set = 1'b0;
        wr_dir = 1'b0;
        rd_en  = start_i && !we_i;
        if (start_i && we_i) begin
            unique case (idx)
                REG_CLEAR: wr_clr = 1'b1;
                REG_SET:   wr_set = 1'b1;
                REG_DIR:   wr_dir = 1'b1;
                REG_PINS:  ; // read-only
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            latch_q <= '0;
        end else if (wr_clr) begin
            latch_q <= latch_q & ~bit_mask;
        end else if (wr_set) begin
            latch_q <= latch_q | bit_mask;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dir_q <= '0;
        end else if (wr_dir) begin
            dir_q <= (dir_q & ~lane_mask_i) | (wdat_i & lane_mask_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdat_q <= '0;
        end else if (rd_en) begin
            unique case (idx)
                REG_CLEAR: rdat_q <= '0;
                REG_SET:   rdat_q <= '0;
                REG_DIR:   rdat_q <= dir_q;
                REG_PINS:  rdat_q <= pins_i;
                default:   rdat_q <= '0;
            endcase
        end
    end

    assign latch_o = latch_q;
    assign dir_o   = dir_q;
    assign rdat_o  = rdat_q;

    AST_CLR_ONLY_LOWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_clr |=> ((latch_q & ~$past(latch_q)) == '0)); // R2

    AST_SET_ONLY_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_set |=> (($past(latch_q) & ~latch_q) == '0)); // R3

    AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_set || wr_clr) |=> $stable(latch_q)); // R9

    AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_dir |=> $stable(dir_q)); // R9

endmodule

// File: rtl/gpio_sc_port.sv
module gpio_sc_port #(
    parameter int ADR_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                bus_cyc,
    input  logic                bus_stb,
    input  logic                bus_we,
    input  logic [ADR_W-1:0]    bus_adr,
    input  logic [DATA_W/8-1:0] bus_sel,
    input  logic [DATA_W-1:0]   bus_wdat,
    output logic [DATA_W-1:0]   bus_rdat,
    output logic                bus_ack,
    output logic [DATA_W-1:0]   pad_out,
    output logic [DATA_W-1:0]   pad_oe,
    input  logic [DATA_W-1:0]   pad_in
);

    localparam int LANES = DATA_W / 8;

    logic              start;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] pins_sync;
    logic [DATA_W-1:0] latch, dir;
    logic              unused_adr;

    assign unused_adr = ^{bus_adr[ADR_W-1:4], bus_adr[1:0]};

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign lane_mask[8*b +: 8] = {8{bus_sel[b]}};
    end

    gpio_sc_bus_fsm u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cyc_i   (bus_cyc),
        .stb_i   (bus_stb),
        .start_o (start),
        .ack_o   (bus_ack)
    );

    gpio_sc_sync #(.WIDTH(DATA_W), .STAGES(2)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pad_in),
        .sync_o  (pins_sync)
    );

    gpio_sc_regs #(.DATA_W(DATA_W)) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start),
        .we_i        (bus_we),
        .idx_i       (bus_adr[3:2]),
        .wdat_i      (bus_wdat),
        .lane_mask_i (lane_mask),
        .pins_i      (pins_sync),
        .latch_o     (latch),
        .dir_o       (dir),
        .rdat_o      (bus_rdat)
    );

    assign pad_out = latch;
    assign pad_oe  = dir;

endmodule

// File: tb/gpio_sc_port_bench.sv
`timescale 1ns/1ps
module gpio_sc_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_cyc = 1'b0, b_stb = 1'b0, b_we = 1'b0;
    logic [7:0]  b_adr = '0;
    logic [3:0]  b_sel = '0;
    logic [31:0] b_wdat = '0, b_rdat, p_out, p_oe;
    logic [31:0] p_in = '0;
    logic        b_ack;

    int n_checks = 0;
    int n_fail   = 0;
    int n_cycles = 0;

    always #2 clk = ~clk;

    gpio_sc_port u_gpio_sc_port (
        .clk_i (clk), .rst_ni (rst_n),
        .bus_cyc (b_cyc), .bus_stb (b_stb), .bus_we (b_we),
        .bus_adr (b_adr), .bus_sel (b_sel), .bus_wdat (b_wdat),
        .bus_rdat (b_rdat), .bus_ack (b_ack),
        .pad_out (p_out), .pad_oe (p_oe), .pad_in (p_in)
    );

    always @(posedge clk) begin
        n_cycles++;
        if (n_cycles > 20000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d cycles, expected below 20000", n_cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // caller stands at a negedge; returns at a negedge
    task automatic access(input logic we, input logic [7:0] adr, input logic [3:0] sel,
                          input logic [31:0] wd, output logic [31:0] rd);
        b_cyc = 1'b1; b_stb = 1'b1; b_we = we; b_adr = adr; b_sel = sel; b_wdat = wd;
        @(negedge clk);
        chk("R6 ack high", {31'b0, b_ack}, 32'd1);
        rd = b_rdat;
        b_cyc = 1'b0; b_stb = 1'b0; b_we = 1'b0;
        @(negedge clk);
        chk("R6 ack single", {31'b0, b_ack}, 32'd0);
    endtask

    typedef struct packed {
        logic        we;
        logic [7:0]  adr;
        logic [3:0]  sel;
        logic [31:0] wd;
        logic        chk_rd;
        logic [31:0] rd;
        logic [31:0] out;
        logic [31:0] oe;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h04, 4'hF, 32'h0000_00FF, 1'b0, 32'h0,         32'h0000_00FF, 32'h0000_0000}, // R3
        '{1'b1, 8'h08, 4'hF, 32'hFFFF_0000, 1'b0, 32'h0,         32'h0000_00FF, 32'hFFFF_0000}, // R4
        '{1'b0, 8'h08, 4'hF, 32'h0,         1'b1, 32'hFFFF_0000, 32'h0000_00FF, 32'hFFFF_0000}, // R4
        '{1'b1, 8'h00, 4'hF, 32'h0000_000F, 1'b0, 32'h0,         32'h0000_00F0, 32'hFFFF_0000}, // R2
        '{1'b1, 8'h04, 4'h4, 32'hFFFF_FFFF, 1'b0, 32'h0,         32'h00FF_00F0, 32'hFFFF_0000}, // R8
        '{1'b0, 8'h04, 4'hF, 32'h0,         1'b1, 32'h0,         32'h00FF_00F0, 32'hFFFF_0000}, // R7
        '{1'b0, 8'h00, 4'hF, 32'h0,         1'b1, 32'h0,         32'h00FF_00F0, 32'hFFFF_0000}, // R7
        '{1'b0, 8'h0C, 4'hF, 32'h0,         1'b1, 32'hA5A5_0F0F, 32'h00FF_00F0, 32'hFFFF_0000}, // R5
        '{1'b1, 8'h0C, 4'hF, 32'h1234_5678, 1'b0, 32'h0,         32'h00FF_00F0, 32'hFFFF_0000}, // R5
        '{1'b0, 8'h0C, 4'hF, 32'h0,         1'b1, 32'hA5A5_0F0F, 32'h00FF_00F0, 32'hFFFF_0000}, // R5
        '{1'b1, 8'h08, 4'h1, 32'h0000_00FF, 1'b0, 32'h0,         32'h00FF_00F0, 32'hFFFF_00FF}, // R8
        '{1'b1, 8'h00, 4'hF, 32'hFFFF_FFFF, 1'b0, 32'h0,         32'h0000_0000, 32'hFFFF_00FF}  // R2
    };

    initial begin
        logic [31:0] rd;
        p_in = 32'hA5A5_0F0F;
        repeat (3) @(negedge clk);
        // R1: state held in reset and just after release
        chk("R1 out in reset", p_out, 32'h0);
        chk("R1 oe in reset", p_oe, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out", p_out, 32'h0);
        chk("R1 oe", p_oe, 32'h0);
        chk("R1 ack", {31'b0, b_ack}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].we, VECS[i].adr, VECS[i].sel, VECS[i].wd, rd);
            if (VECS[i].chk_rd) chk($sformatf("vec %0d R4/R5/R7 read", i), rd, VECS[i].rd);
            chk($sformatf("vec %0d R2/R3/R8 out", i), p_out, VECS[i].out);
            chk($sformatf("vec %0d R4/R8 oe", i), p_oe, VECS[i].oe);
        end

        // R9: strobe without cycle, then cycle without strobe
        b_cyc = 1'b0; b_stb = 1'b1; b_we = 1'b1; b_adr = 8'h04; b_sel = 4'hF; b_wdat = '1;
        repeat (3) @(negedge clk);
        chk("R9 no ack stb only", {31'b0, b_ack}, 32'h0);
        chk("R9 out stb only", p_out, 32'h0);
        b_cyc = 1'b1; b_stb = 1'b0; b_adr = 8'h08;
        repeat (3) @(negedge clk);
        chk("R9 no ack cyc only", {31'b0, b_ack}, 32'h0);
        chk("R9 oe cyc only", p_oe, 32'hFFFF_00FF);
        b_cyc = 1'b0; b_we = 1'b0;
        @(negedge clk);

        // R5 synchronizer latency
        p_in = 32'h3C3C_C3C3;
        access(1'b0, 8'h0C, 4'hF, 32'h0, rd);
        chk("R5 read on first edge is old", rd, 32'hA5A5_0F0F);
        access(1'b0, 8'h0C, 4'hF, 32'h0, rd);
        chk("R5 read later is new", rd, 32'h3C3C_C3C3);

        // R1: reset in mid-run
        access(1'b1, 8'h04, 4'hF, 32'hFFFF_FFFF, rd);
        chk("R3 all set", p_out, 32'hFFFF_FFFF);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 out after reset", p_out, 32'h0);
        chk("R1 oe after reset", p_oe, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule